// File: doc/BRIEF.md
# Fat-Tree Up/Down Route Selector

This block makes the output-port decision for one switch in a k-ary fat tree. Each cycle it may accept one packet header that carries a destination leaf address. The switch supplies its own level in the tree and the address prefix of the subtree below it. From these the block decides whether the packet must climb or can descend.

If any destination digit above the switch's level differs from the switch's prefix, the destination lies outside the subtree. The packet then goes up on one of several parallel parent links. A free-running LFSR draws a candidate link. If that link is marked unavailable, the next available link in circular order is used instead.

If every prefix digit matches, the packet descends. The child port is the destination's digit at the switch's level. Downward routes are fully deterministic. Upward and downward choices are reported with a direction flag, so the two kinds of channel stay separate resources. The decision is registered and appears one cycle after the header is accepted.

Top module: `fat_tree_route_sel`

## Requirements
- R1: After reset, `route_valid` is 0.
- R2: A header accepted on a clock edge (`hdr_valid` and `hdr_ready` both 1) produces `route_valid`=1 after that edge. A cycle with no accepted header produces `route_valid`=0 after the edge.
- R3: Addresses are LEVELS base-K digits, and digit 0 is the most significant. If any destination digit at an index below `sw_level` differs from the same digit of `sw_prefix`, the route is upward (`route_up`=1).
- R4: If all such digits match, the route is downward (`route_up`=0). `route_port` then equals the destination digit at index `sw_level`.
- R5: A switch at level 0 (the root) never routes upward, whatever `sw_prefix` and `up_avail` hold.
- R6: An upward `route_port` always indexes a bit that was 1 in `up_avail` when the header was accepted.
- R7: When exactly one bit of `up_avail` is set, every upward route uses that port.
- R8: A header that needs to go up while `up_avail` is all zero is held: `hdr_ready` is 0 and no route is produced. It is accepted once a link becomes available. An empty mask does not stall downward headers.
- R9: Headers presented on consecutive cycles are each accepted and routed, one per cycle.
- R10: With all up links available, a run of 32 consecutive upward decisions uses at least two different ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Header can be accepted this cycle |
| hdr_dest | input | LEVELS*log2(K) | Destination leaf address, digit 0 in the top bits |
| sw_level | input | log2(LEVELS) | Level of this switch, 0 = root |
| sw_prefix | input | LEVELS*log2(K) | Address prefix of this switch's subtree; only digits below `sw_level` are used |
| up_avail | input | UP_PORTS | Per parent link: 1 = usable |
| route_valid | output | 1 | Registered decision is valid |
| route_up | output | 1 | 1 = upward link, 0 = downward child |
| route_port | output | max(log2(K), log2(UP_PORTS)) | Chosen port index |

## Verification
Two things can meet in the same cycle: the random up-link draw and the availability mask that can veto it. When they do, the round-robin fallback must find a usable link. Its limiting case is an empty mask, which must stall an upward header without disturbing a downward one.

The bench provokes these cases with sparse masks (one bit, two bits, none) during streams of back-to-back upward headers. The drawn candidate is then often vetoed. Each result is judged only against the mask applied in the accepting cycle, since the draw itself is not visible at the ports. A downward header is also sent with an empty mask, and an upward header is released by raising one mask bit while it is held.

// File: rtl/fat_tree_route_sel.sv
module fat_tree_route_sel #(
  parameter int K         = 4,
  parameter int LEVELS    = 3,
  parameter int UP_PORTS  = 4,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         hdr_valid,
  output logic                         hdr_ready,
  input  logic [LEVELS*$clog2(K)-1:0]  hdr_dest,
  input  logic [$clog2(LEVELS)-1:0]    sw_level,
  input  logic [LEVELS*$clog2(K)-1:0]  sw_prefix,
  input  logic [UP_PORTS-1:0]          up_avail,
  output logic                         route_valid,
  output logic                         route_up,
  output logic [(($clog2(K) > $clog2(UP_PORTS)) ? $clog2(K) : $clog2(UP_PORTS))-1:0] route_port
);
  localparam int DW = $clog2(K);
  localparam int AW = LEVELS * DW;
  localparam int UW = $clog2(UP_PORTS);
  localparam int PW = (DW > UW) ? DW : UW;

  logic [15:0]   lfsr;
  logic          go_up, found;
  logic [DW-1:0] down_port;
  logic [UW-1:0] up_port;
  logic          fire;

  always_comb begin
    go_up     = 1'b0;
    down_port = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (i < int'(sw_level) &&
          hdr_dest[AW-1-i*DW -: DW] != sw_prefix[AW-1-i*DW -: DW])
        go_up = 1'b1;
      if (i == int'(sw_level))
        down_port = hdr_dest[AW-1-i*DW -: DW];
    end
  end

  always_comb begin
    int draw;
    draw    = int'(lfsr) % UP_PORTS;
    up_port = '0;
    found   = 1'b0;
    for (int o = 0; o < UP_PORTS; o++) begin
      int cand;
      cand = (draw + o) % UP_PORTS;
      if (!found && up_avail[cand]) begin
        up_port = UW'(cand);
        found   = 1'b1;
      end
    end
  end

  assign hdr_ready = !(go_up && !found);
  assign fire      = hdr_valid && hdr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr        <= LFSR_SEED;
      route_valid <= 1'b0;
      route_up    <= 1'b0;
      route_port  <= '0;
    end else begin
      lfsr        <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      route_valid <= fire;
      if (fire) begin
        route_up   <= go_up;
        route_port <= go_up ? PW'(up_port) : PW'(down_port);
      end
    end
  end
endmodule

// File: rtl/fat_tree_route_sel_chk.sv
module fat_tree_route_sel_chk #(
  parameter int K        = 4,
  parameter int LEVELS   = 3,
  parameter int UP_PORTS = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        hdr_valid,
  input logic                        hdr_ready,
  input logic [$clog2(LEVELS)-1:0]   sw_level,
  input logic [UP_PORTS-1:0]         up_avail,
  input logic                        route_valid,
  input logic                        route_up,
  input logic [(($clog2(K) > $clog2(UP_PORTS)) ? $clog2(K) : $clog2(UP_PORTS))-1:0] route_port
);
  a_r2_accept_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready) |=> route_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_valid && hdr_ready) |=> !route_valid);

  a_r5_root_never_up: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready && sw_level == '0) |=> !route_up);

  a_r6_up_port_available: assert property (@(posedge clk) disable iff (!rst_n)
    (route_valid && route_up) |-> (($past(up_avail) >> route_port) & 1) != 0);

  a_r8_stall_only_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_ready |-> (up_avail == '0));
endmodule

bind fat_tree_route_sel fat_tree_route_sel_chk #(
  .K(K), .LEVELS(LEVELS), .UP_PORTS(UP_PORTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
  .sw_level(sw_level), .up_avail(up_avail), .route_valid(route_valid),
  .route_up(route_up), .route_port(route_port)
);

// File: tb/fat_tree_route_sel_bench.sv
module fat_tree_route_sel_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hdr_valid = 1'b0;
  logic       hdr_ready;
  logic [5:0] hdr_dest = '0;
  logic [1:0] sw_level = '0;
  logic [5:0] sw_prefix = '0;
  logic [3:0] up_avail = 4'b1111;
  logic       route_valid, route_up;
  logic [1:0] route_port;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  fat_tree_route_sel u_fat_tree_route_sel (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_dest(hdr_dest), .sw_level(sw_level), .sw_prefix(sw_prefix),
    .up_avail(up_avail), .route_valid(route_valid), .route_up(route_up),
    .route_port(route_port)
  );

  function automatic logic [5:0] mk(int a, int b, int c);
    return {a[1:0], b[1:0], c[1:0]};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge; drives one header and checks the routed result one edge later.
  // exp_port < 0 means any port whose up_avail bit is set.
  task automatic step(logic [5:0] d, int lvl, logic [5:0] pre, logic [3:0] av,
                      bit exp_up, int exp_port, string req);
    hdr_dest = d; sw_level = lvl[1:0]; sw_prefix = pre; up_avail = av; hdr_valid = 1'b1;
    #1 chk(hdr_ready == 1'b1, req, int'(hdr_ready), 1);
    @(posedge clk); @(negedge clk);
    chk(route_valid == 1'b1, req, int'(route_valid), 1);
    chk(route_up == exp_up, req, int'(route_up), int'(exp_up));
    if (exp_port >= 0) chk(int'(route_port) == exp_port, req, int'(route_port), exp_port);
    else chk(av[route_port] == 1'b1, req, int'(route_port), -1);
  endtask

  task automatic idle();
    hdr_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(route_valid == 1'b0, "R2 idle", int'(route_valid), 0);
  endtask

  task automatic t_reset();
    chk(route_valid == 1'b0, "R1 reset", int'(route_valid), 0);
  endtask

  task automatic t_down();
    step(mk(1,2,3), 2, mk(1,2,0), 4'b1111, 1'b0, 3, "R4 level2 down");
    step(mk(3,0,2), 1, mk(3,1,1), 4'b1111, 1'b0, 0, "R4 level1 down");
    step(mk(2,1,1), 2, mk(2,1,3), 4'b0000, 1'b0, 1, "R8 down with empty mask");
    idle();
  endtask

  task automatic t_up();
    step(mk(1,3,0), 2, mk(1,2,0), 4'b1111, 1'b1, -1, "R3 mismatch digit1");
    step(mk(0,2,0), 1, mk(3,2,0), 4'b1111, 1'b1, -1, "R3 mismatch digit0");
    idle();
  endtask

  task automatic t_root();
    step(mk(2,0,1), 0, mk(1,3,3), 4'b0000, 1'b0, 2, "R5 root down");
    step(mk(0,3,1), 0, mk(3,3,3), 4'b1111, 1'b0, 0, "R5 root down");
    idle();
  endtask

  task automatic t_single();
    for (int i = 0; i < 8; i++)
      step(mk(3,3,0), 2, mk(0,0,0), 4'b0100, 1'b1, 2, "R7 single link");
    idle();
  endtask

  task automatic t_sparse();
    for (int i = 0; i < 16; i++)
      step(mk(3,0,0), 1, mk(1,0,0), 4'b1010, 1'b1, -1, "R6 sparse mask");
    idle();
  endtask

  task automatic t_stream();
    logic [3:0] seen = '0;
    for (int i = 0; i < 32; i++) begin
      step(mk(2,2,2), 2, mk(1,1,1), 4'b1111, 1'b1, -1, "R9 back-to-back");
      seen[route_port] = 1'b1;
    end
    chk($countones(seen) >= 2, "R10 spread", $countones(seen), 2);
    idle();
  endtask

  task automatic t_blocked();
    hdr_dest = mk(3,1,0); sw_level = 2'd2; sw_prefix = mk(0,1,0); up_avail = 4'b0000;
    hdr_valid = 1'b1;
    #1 chk(hdr_ready == 1'b0, "R8 held", int'(hdr_ready), 0);
    @(posedge clk); @(negedge clk);
    chk(route_valid == 1'b0, "R8 no route", int'(route_valid), 0);
    up_avail = 4'b0001;
    #1 chk(hdr_ready == 1'b1, "R8 released", int'(hdr_ready), 1);
    @(posedge clk); @(negedge clk);
    chk(route_valid == 1'b1 && route_up == 1'b1, "R8 routed", int'(route_up), 1);
    chk(route_port == 2'd0, "R8 port", int'(route_port), 0);
    idle();
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, -1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_down();
    t_up();
    t_root();
    t_single();
    t_sparse();
    t_stream();
    t_blocked();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule